// File: doc/BRIEF.md
# Timebase Interval Timer

This block is a free-running prescaler clocked by the main oscillator clock. It gives software a periodic interval event. It also gives a companion watchdog a set of carry pulses to count. The timer holds 18 counter bits behind a divide-by-two stage. A full turn of the timer therefore covers 2^(CNT_W+1) input clocks. A 2-bit select field picks one of four power-of-two tap periods: 2^(CNT_W-6), 2^(CNT_W-4), 2^(CNT_W-2) or 2^(CNT_W+1) clocks. With the default CNT_W of 18, these are 2^12, 2^14, 2^16 and 2^19 clocks.

When the selected period elapses, a sticky flag is set. The flag, ANDed with an interrupt enable bit, forms the interrupt request. Software controls the block through a single control byte that it writes with a strobe. Writing the clear bit restarts the timer from zero and drops the flag. The same write also raises a one-cycle clear toward the watchdog. Each tap drives a carry output that is high in the cycle just before that tap's count wraps. The watchdog can use these outputs as clock enables.

Top module: `tbt_timebase`

## Requirements
- R1: After a synchronous reset, rd_data reads 8'h84 and irq is 0. In rd_data, bit 7 reads 1, bits 6:5 read 0, bit 4 is the enable, bit 3 is the flag, bit 2 reads 1 and bits 1:0 are the select field.
- R2: With select code 00, 01, 10 or 11 in wr_data[1:0], the flag sets on the clock edge that completes 2^(CNT_W-6), 2^(CNT_W-4), 2^(CNT_W-2) or 2^(CNT_W+1) clocks since the last reset or clear. It sets again on every later multiple of that period.
- R3: irq is 1 exactly when both the flag and the enable (wr_data[4] as last written) are 1.
- R4: A write with wr_data[3]=0 clears the flag. A write with wr_data[3]=1 leaves the flag unchanged.
- R5: If a period completes on the same edge as a write with wr_data[3]=0, the flag ends up set.
- R6: A write with wr_data[2]=1 restarts the count from zero and clears the flag. This holds even when a period completes on the same edge.
- R7: tap_carry[i] is 1 exactly in the cycles where the next edge completes a multiple of tap i's period. Tap i uses the period of select code i.
- R8: wdg_clr is 1 in exactly the cycles where wr_en is 1 and wr_data[2] is 1.
- R9: Each write stores wr_data[4] as the enable and wr_data[1:0] as the select field, and both read back on rd_data.
- R10: Once set, the flag stays set until a flag-clear write, a timer clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 5 | Writable control bits: [4] enable, [3] flag, [2] clear, [1:0] select |
| rd_data | output | 8 | Control byte read value |
| irq | output | 1 | Interval interrupt request |
| tap_carry | output | 4 | Per-tap carry pulses for the watchdog |
| wdg_clr | output | 1 | Watchdog counter clear |

## Verification
An error in the count shows up on tap_carry. The carry for the shortest tap pulses every 2^(CNT_W-6) clocks, so a wrong count is visible within one short period. A flag that sets on the wrong tap, or that fails to stay set, shows on rd_data bit 3 and on irq. This becomes visible at the first period edge, or in the first cycle after the wrong update. The hard cases are collisions between a write and a period edge. The bench times these writes from its own model of the count, so that each write lands exactly on a set edge.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int NUM_TAPS = 4;

    localparam int BIT_IE   = 4;
    localparam int BIT_FLAG = 3;
    localparam int BIT_CLR  = 2;

    typedef logic [1:0] sel_t;

    typedef struct packed {
        logic ie;
        logic flag_keep;
        logic clr;
        sel_t sel;
    } wr_fields_t;

    // Period exponent, in input clocks, for each tap
    function automatic int tap_exp(input int idx, input int cnt_w);
        case (idx)
            0:       return cnt_w - 6;
            1:       return cnt_w - 4;
            2:       return cnt_w - 2;
            default: return cnt_w + 1;
        endcase
    endfunction

    function automatic wr_fields_t decode_wr(input logic [4:0] d);
        wr_fields_t f;
        f.ie        = d[BIT_IE];
        f.flag_keep = d[BIT_FLAG];
        f.clr       = d[BIT_CLR];
        f.sel       = d[1:0];
        return f;
    endfunction

    function automatic logic [7:0] pack_rd(input logic ie, input logic flag, input sel_t sel);
        return {1'b1, 2'b00, ie, flag, 1'b1, sel};
    endfunction

endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler
    import tbt_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    output logic [NUM_TAPS-1:0] tick
);

    logic             half;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            half <= 1'b0;
            cnt  <= '0;
        end else begin
            half <= ~half;
            if (half) cnt <= cnt + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int TOP = tap_exp(g, CNT_W) - 2;
        // next edge drops counter bit TOP
        assign tick[g] = half & (&cnt[TOP:0]);

        if (g > 0) begin : g_nest
            // R7: a longer period always coincides with every shorter one
            assert_tap_nesting_R7: assert property (@(posedge clk) disable iff (rst)
                tick[g] |-> tick[g-1]);
        end
    end

    // R6: a clear restarts the count from zero
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && !half));

    // R2: without a clear the count only moves forward by one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && half) |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/tbt_ctrl.sv
module tbt_ctrl
    import tbt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  wr_fields_t          wf,
    input  logic [NUM_TAPS-1:0] tick,
    output logic                ie,
    output logic                flag,
    output sel_t                sel
);

    logic set_evt;
    logic clr_evt;

    assign set_evt = tick[sel];
    assign clr_evt = wr_en & wf.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie  <= 1'b0;
            sel <= '0;
        end else if (wr_en) begin
            ie  <= wf.ie;
            sel <= wf.sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_evt)                     flag <= 1'b0;
        else if (set_evt)                       flag <= 1'b1;
        else if (wr_en && !wf.flag_keep)        flag <= 1'b0;
    end

    // R2: the flag only rises on a selected tap event
    assert_flag_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(set_evt));

    // R6: a timer clear leaves the flag low
    assert_clear_flag_R6: assert property (@(posedge clk) disable iff (rst)
        clr_evt |=> !flag);

    // R10: flag holds unless a write happens
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_en) |=> flag);

    // R9: fields change only through a write
    assert_fields_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ie) && $stable(sel)));

endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase
    import tbt_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [4:0]          wr_data,
    output logic [7:0]          rd_data,
    output logic                irq,
    output logic [NUM_TAPS-1:0] tap_carry,
    output logic                wdg_clr
);

    wr_fields_t          wf;
    logic [NUM_TAPS-1:0] tick;
    logic                ie;
    logic                flag;
    sel_t                sel;

    assign wf      = decode_wr(wr_data);
    assign wdg_clr = wr_en & wf.clr;

    tbt_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (wdg_clr),
        .tick (tick)
    );

    tbt_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wf    (wf),
        .tick  (tick),
        .ie    (ie),
        .flag  (flag),
        .sel   (sel)
    );

    assign tap_carry = tick;
    assign irq       = flag & ie;
    assign rd_data   = pack_rd(ie, flag, sel);

    // R3: a request needs the flag bit to be set
    assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> rd_data[BIT_FLAG]);

endmodule

// File: tb/tbt_timebase_tb.sv
module tbt_timebase_tb;

    localparam int CNT_W = 10;
    localparam int EXPS[4] = '{CNT_W-6, CNT_W-4, CNT_W-2, CNT_W+1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;
    logic [3:0] tap_carry;
    logic       wdg_clr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    string phase = "R1";

    // reference state
    int   m_t = 0;
    bit   m_flag = 0;
    bit   m_ie = 0;
    int   m_sel = 0;

    always #10 clk = ~clk;

    tbt_timebase #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .tap_carry(tap_carry), .wdg_clr(wdg_clr)
    );

    function automatic bit wraps(int t, int e);
        return ((t + 1) % (1 << e)) == 0;
    endfunction

    always @(posedge clk) begin
        bit clr, set;
        cyc++;
        if (rst) begin
            m_t = 0; m_flag = 0; m_ie = 0; m_sel = 0;
        end else begin
            clr = wr_en && wr_data[2];
            set = wraps(m_t, EXPS[m_sel]);
            if (clr) begin
                m_t = 0; m_flag = 0;
            end else begin
                m_t = m_t + 1;
                if (set) m_flag = 1;
                else if (wr_en && !wr_data[3]) m_flag = 0;
            end
            if (wr_en) begin
                m_ie = wr_data[4];
                m_sel = int'(wr_data[1:0]);
            end
        end
        #5;
        cmp_all();
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", phase, what, cyc, act, exp);
        end
    endtask

    task automatic cmp_all();
        logic [3:0] ec;
        for (int i = 0; i < 4; i++) ec[i] = wraps(m_t, EXPS[i]);
        // R1 R9 R10: readback of the control byte
        chk("rd_data", rd_data, {1'b1, 2'b00, m_ie, m_flag, 1'b1, 2'(m_sel)});
        chk("irq R3", {7'd0, irq}, {7'd0, m_flag & m_ie});
        chk("tap_carry R7", {4'd0, tap_carry}, {4'd0, ec});
        chk("wdg_clr R8", {7'd0, wdg_clr}, {7'd0, wr_en & wr_data[2]});
    endtask

    task automatic write(logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive a write so that it lands on the next set edge of the selected tap
    task automatic write_on_set(logic [4:0] d);
        @(negedge clk);
        while (!wraps(m_t, EXPS[m_sel])) @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        phase = "R1";
        idle(4);

        phase = "R9";
        write(5'b01001);
        write(5'b11110);
        idle(3);

        phase = "R2";
        for (int s = 0; s < 4; s++) begin
            write(5'b01100 | 5'(s));
            idle((1 << EXPS[s]) + 4);
        end

        phase = "R10";
        idle(50);

        phase = "R4";
        write(5'b00000);
        idle(3);
        write(5'b01000);
        idle(40);

        phase = "R3";
        write(5'b11000);
        idle(40);
        write(5'b01000);
        idle(5);

        phase = "R5";
        write(5'b11100);
        write_on_set(5'b10000);
        idle(5);
        write_on_set(5'b10001);
        idle(3);

        phase = "R6";
        write(5'b10100);
        write_on_set(5'b10100);
        idle(30);

        phase = "R8";
        for (int k = 0; k < 60; k++) begin
            write(5'((k * 7 + 3) % 32) & 5'b11011 | ((k % 9 == 0) ? 5'b00100 : 5'b0));
            idle(k % 11);
        end
        idle(300);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule